// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks which lanes of one lockstep warp are enabled as the warp's shared instruction stream moves through conditional code. Every lane runs the same instruction in a cycle. When a conditional branch resolves with some enabled lanes going one way and the rest going the other, the block does not try to follow both at once. It runs the taken side first with only the taken lanes enabled. It keeps the pending side and the point where the two sides meet on a small hardware stack. When the running path reaches that meeting point, the block switches to the pending side, and after that it restores the mask the warp had before the split. The per-lane write-enable mask that results gates writeback, so disabled lanes leave no results.

The block makes no prediction and no speculation. It decides the next program counter only after the branch outcome for the current instruction arrives with `step_i`. It never issues an instruction on a path that has no enabled lanes. Its outputs are the program counter to issue next and the lane enable mask. The stack holds `DEPTH` entries. A split that does not fit sets a sticky overflow flag and leaves the stack contents as they were.

All inputs are plain control pins sampled on the rising clock edge when `step_i` is high. The block accepts one resolved instruction per cycle, so there is no back-pressure and no ready signal. The caller must supply a reconvergence PC that differs from the taken target. Nested regions must use distinct reconvergence PCs.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, `pc_o` equals `RESET_PC`, every bit of `lane_en_o` is 1, `overflow_o` is 0 and the stack is empty.
- R2: A step with `br_i`=0 moves `pc_o` to `pc_o`+1 and keeps `lane_en_o`, unless the pop rule (R6) applies. With `step_i`=0, `pc_o` and `lane_en_o` hold.
- R3: A branch considers only predicate bits of enabled lanes; bit k of `pred_i` belongs to lane k and 1 means taken. Predicate bits of disabled lanes are ignored. If every enabled lane is taken, the next PC is `tgt_i`. If none is taken, the next PC is `fall_i`. The mask is unchanged and nothing is pushed.
- R4: A split branch (enabled lanes disagree) runs the taken path first: the next PC is `tgt_i` and the mask is the taken enabled lanes. It pushes a restore entry {reconv `reconv_i`, resume `reconv_i`, the mask before the split} and then a pending entry {reconv `reconv_i`, resume `fall_i`, the not-taken enabled lanes}.
- R5: When `fall_i` equals `reconv_i` on a split, only the restore entry is pushed. The not-taken lanes get no issue of their own, and `lane_en_o` is never all zero.
- R6: In a step that pushes nothing, if the stack is not empty and the computed next PC equals the top entry's reconvergence PC, the top entry is popped. The warp continues at its resume PC with its mask. At most one pop happens per step.
- R7: A split needing more free entries than remain sets `overflow_o`, which stays set until reset. The stack is left unchanged, and the warp goes on along the taken path with the taken lanes only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | The instruction at `pc_o` has resolved this cycle |
| br_i | input | 1 | The resolved instruction is a conditional branch |
| pred_i | input | LANES | Per-lane branch outcome, 1 = taken |
| tgt_i | input | PC_W | Taken target PC |
| fall_i | input | PC_W | Fall-through PC |
| reconv_i | input | PC_W | Reconvergence PC of this branch |
| pc_o | output | PC_W | PC to issue next |
| lane_en_o | output | LANES | Per-lane write-enable mask for the issued instruction |
| overflow_o | output | 1 | Sticky: a split did not fit on the stack |

## Verification
The predicates tried are as follows:
- All enabled lanes true and all false. These tell a plain jump and a plain fall-through apart from a split.
- A split whose predicate has set bits on disabled lanes. This shows that only enabled lanes count.
- Two nested splits. These fill the stack, and the pops unwind in last-in order with the right masks.
- A third split on a full stack. Later pops that still land correctly show that the failed push left the stack intact.
- An if-without-else, where the fall-through is the meeting point. This shows that no empty path is issued.

// File: rtl/simt_reconv_pkg.sv
package simt_reconv_pkg;
  typedef enum logic [1:0] {
    KIND_SEQ   = 2'd0,
    KIND_FALL  = 2'd1,
    KIND_JUMP  = 2'd2,
    KIND_SPLIT = 2'd3
  } step_kind_e;
endpackage

// File: rtl/simt_lane_split.sv
module simt_lane_split
  import simt_reconv_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] act_i,
  input  logic [LANES-1:0] pred_i,
  input  logic             br_i,
  output logic [LANES-1:0] taken_o,
  output logic [LANES-1:0] fall_o,
  output step_kind_e       kind_o
);
  // Only lanes currently enabled take part in the decision
  assign taken_o = pred_i & act_i;
  assign fall_o  = ~pred_i & act_i;

  always_comb begin
    if (!br_i)                 kind_o = KIND_SEQ;
    else if (taken_o == '0)    kind_o = KIND_FALL;
    else if (fall_o == '0)     kind_o = KIND_JUMP;
    else                       kind_o = KIND_SPLIT;
  end
endmodule

// File: rtl/simt_path_stack.sv
module simt_path_stack #(
  parameter int LANES = 8,
  parameter int PC_W  = 16,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [1:0]       push_n_i,
  input  logic [PC_W-1:0]  a_rpc_i,
  input  logic [PC_W-1:0]  a_npc_i,
  input  logic [LANES-1:0] a_mask_i,
  input  logic [PC_W-1:0]  b_rpc_i,
  input  logic [PC_W-1:0]  b_npc_i,
  input  logic [LANES-1:0] b_mask_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] count_o,
  output logic [PC_W-1:0]  top_rpc_o,
  output logic [PC_W-1:0]  top_npc_o,
  output logic [LANES-1:0] top_mask_o
);
  logic [PC_W-1:0]  rpc_q  [DEPTH];
  logic [PC_W-1:0]  npc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_pos;
  logic [IDX_W-1:0] top_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        rpc_q[i]  <= '0;
        npc_q[i]  <= '0;
        mask_q[i] <= '0;
      end else if (push_n_i != 2'd0 && cnt_q == CNT_W'(i)) begin
        rpc_q[i]  <= a_rpc_i;
        npc_q[i]  <= a_npc_i;
        mask_q[i] <= a_mask_i;
      end else if (push_n_i == 2'd2 && cnt_q + CNT_W'(1) == CNT_W'(i)) begin
        rpc_q[i]  <= b_rpc_i;
        npc_q[i]  <= b_npc_i;
        mask_q[i] <= b_mask_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                 cnt_q <= '0;
    else if (push_n_i != 2'd0) cnt_q <= cnt_q + CNT_W'(push_n_i);
    else if (pop_i)            cnt_q <= cnt_q - CNT_W'(1);
  end

  assign top_pos    = cnt_q - CNT_W'(1);
  assign top_idx    = top_pos[IDX_W-1:0];
  assign count_o    = cnt_q;
  assign top_rpc_o  = rpc_q[top_idx];
  assign top_npc_o  = npc_q[top_idx];
  assign top_mask_o = mask_q[top_idx];
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_reconv_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int PC_W     = 16,
  parameter int DEPTH    = 4,
  parameter int RESET_PC = 0,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  input  logic             br_i,
  input  logic [LANES-1:0] pred_i,
  input  logic [PC_W-1:0]  tgt_i,
  input  logic [PC_W-1:0]  fall_i,
  input  logic [PC_W-1:0]  reconv_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] lane_en_o,
  output logic             overflow_o
);
  logic [PC_W-1:0]  pc_q;
  logic [LANES-1:0] mask_q;
  logic             ovf_q;

  logic [LANES-1:0] taken_m, fall_m;
  step_kind_e       kind;

  logic [1:0]       push_n, need_n;
  logic             pop, ovf_set, room;
  logic [PC_W-1:0]  nxt_pc;
  logic [LANES-1:0] nxt_mask;
  logic [CNT_W-1:0] count;
  logic [PC_W-1:0]  top_rpc, top_npc;
  logic [LANES-1:0] top_mask;

  simt_lane_split #(.LANES(LANES)) split_i (
    .act_i  (mask_q),
    .pred_i (pred_i),
    .br_i   (br_i),
    .taken_o(taken_m),
    .fall_o (fall_m),
    .kind_o (kind)
  );

  simt_path_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) stack_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .push_n_i  (push_n),
    .a_rpc_i   (reconv_i),
    .a_npc_i   (reconv_i),
    .a_mask_i  (mask_q),
    .b_rpc_i   (reconv_i),
    .b_npc_i   (fall_i),
    .b_mask_i  (fall_m),
    .pop_i     (pop),
    .count_o   (count),
    .top_rpc_o (top_rpc),
    .top_npc_o (top_npc),
    .top_mask_o(top_mask)
  );

  // If-without-else needs only the restore entry
  assign need_n = (fall_i == reconv_i) ? 2'd1 : 2'd2;
  assign room   = ({1'b0, count} + (CNT_W+1)'(need_n)) <= (CNT_W+1)'(DEPTH);

  always_comb begin
    nxt_pc   = pc_q + PC_W'(1);
    nxt_mask = mask_q;
    push_n   = 2'd0;
    pop      = 1'b0;
    ovf_set  = 1'b0;
    if (step_i) begin
      unique case (kind)
        KIND_FALL: nxt_pc = fall_i;
        KIND_JUMP: nxt_pc = tgt_i;
        KIND_SPLIT: begin
          nxt_pc   = tgt_i;
          nxt_mask = taken_m;
          if (room) push_n  = need_n;
          else      ovf_set = 1'b1;
        end
        default: ;
      endcase
      if (push_n == 2'd0 && count != '0 && nxt_pc == top_rpc) begin
        pop      = 1'b1;
        nxt_pc   = top_npc;
        nxt_mask = top_mask;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_q   <= PC_W'(RESET_PC);
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else begin
      if (step_i) begin
        pc_q   <= nxt_pc;
        mask_q <= nxt_mask;
      end
      if (ovf_set) ovf_q <= 1'b1;
    end
  end

  assign pc_o       = pc_q;
  assign lane_en_o  = mask_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/simt_reconv_chk.sv
module simt_reconv_chk #(
  parameter int LANES    = 8,
  parameter int PC_W     = 16,
  parameter int RESET_PC = 0
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             step_i,
  input logic             br_i,
  input logic [LANES-1:0] pred_i,
  input logic [PC_W-1:0]  pc_o,
  input logic [LANES-1:0] lane_en_o,
  input logic             overflow_o
);
  AST_RESET_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (pc_o == PC_W'(RESET_PC) && lane_en_o == '1 && !overflow_o)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> ($stable(pc_o) && $stable(lane_en_o))); // R2

  AST_SPLIT_MASK: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && br_i && (pred_i & lane_en_o) != '0 && (~pred_i & lane_en_o) != '0)
      |=> lane_en_o == $past(pred_i & lane_en_o)); // R4

  AST_NO_EMPTY_ISSUE: assert property (@(posedge clk_i) disable iff (rst_i)
    lane_en_o != '0); // R5

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    overflow_o |=> overflow_o); // R7
endmodule

bind simt_reconv_stack simt_reconv_chk #(
  .LANES(LANES), .PC_W(PC_W), .RESET_PC(RESET_PC)
) chk_i (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .step_i    (step_i),
  .br_i      (br_i),
  .pred_i    (pred_i),
  .pc_o      (pc_o),
  .lane_en_o (lane_en_o),
  .overflow_o(overflow_o)
);

// File: tb/simt_reconv_stack_tb_top.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb_top;
  localparam int LANES = 8;
  localparam int PC_W  = 16;
  localparam int DEPTH = 4;

  logic             clk_i = 1'b0;
  logic             rst_i = 1'b1;
  logic             step_i = 1'b0;
  logic             br_i = 1'b0;
  logic [LANES-1:0] pred_i = '0;
  logic [PC_W-1:0]  tgt_i = '0, fall_i = '0, reconv_i = '0;
  logic [PC_W-1:0]  pc_o;
  logic [LANES-1:0] lane_en_o;
  logic             overflow_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [PC_W-1:0]  q_pc[$];
  logic [LANES-1:0] q_mask[$];
  string            q_tag[$];

  always #5 clk_i = ~clk_i;

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .RESET_PC(0)) dut_i (
    .clk_i, .rst_i, .step_i, .br_i, .pred_i, .tgt_i, .fall_i, .reconv_i,
    .pc_o, .lane_en_o, .overflow_o
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: records the expected result and presents one resolved instruction
  task automatic issue(bit br, logic [LANES-1:0] pred, int tgt, int fall, int rc,
                       int exp_pc, logic [LANES-1:0] exp_mask, string tag);
    q_pc.push_back(PC_W'(exp_pc));
    q_mask.push_back(exp_mask);
    q_tag.push_back(tag);
    @(negedge clk_i);
    step_i = 1'b1; br_i = br; pred_i = pred;
    tgt_i = PC_W'(tgt); fall_i = PC_W'(fall); reconv_i = PC_W'(rc);
    @(negedge clk_i);
    step_i = 1'b0; br_i = 1'b0;
  endtask

  // Monitor: compares the state produced by each step, sampled after the edge
  always @(posedge clk_i) begin
    if (step_i && !rst_i) begin
      #2;
      if (q_pc.size() == 0) begin
        check("monitor queue empty", 1, 0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check({t, " pc"}, int'(pc_o), int'(q_pc.pop_front()));
        check({t, " mask"}, int'(lane_en_o), int'(q_mask.pop_front()));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    logic [PC_W-1:0] held;
    repeat (3) @(negedge clk_i);
    rst_i = 1'b0;
    @(negedge clk_i);
    check("R1 reset pc", int'(pc_o), 0);
    check("R1 reset mask", int'(lane_en_o), 'hFF);
    check("R1 reset overflow", int'(overflow_o), 0);

    issue(0, 8'h00, 0, 0, 0, 1, 8'hFF, "R2 sequential");
    issue(1, 8'hFF, 10, 2, 20, 10, 8'hFF, "R3 uniform taken");
    issue(1, 8'h00, 30, 11, 40, 11, 8'hFF, "R3 uniform fall");
    issue(1, 8'h0F, 50, 12, 60, 50, 8'h0F, "R4 split taken first");
    issue(0, 8'h00, 0, 0, 0, 51, 8'h0F, "R2 sequential in path");
    issue(1, 8'hF3, 70, 52, 59, 70, 8'h03, "R3 R4 nested split, idle lanes ignored");
    @(negedge clk_i);
    check("R7 no overflow with stack full", int'(overflow_o), 0);
    issue(1, 8'h01, 80, 71, 75, 80, 8'h01, "R7 split on full stack");
    @(negedge clk_i);
    check("R7 overflow set", int'(overflow_o), 1);
    issue(1, 8'hFF, 59, 81, 0, 52, 8'h0C, "R6 pop pending inner path");
    issue(0, 8'h00, 0, 0, 0, 53, 8'h0C, "R2 sequential in pending path");
    issue(1, 8'h0C, 59, 54, 0, 59, 8'h0F, "R6 R7 pop inner restore, stack intact");
    issue(0, 8'h00, 0, 0, 0, 12, 8'hF0, "R6 pop outer pending path");
    issue(0, 8'h00, 0, 0, 0, 13, 8'hF0, "R2 sequential");
    issue(1, 8'h00, 99, 60, 0, 60, 8'hFF, "R6 pop outer restore");
    issue(0, 8'h00, 0, 0, 0, 61, 8'hFF, "R6 empty stack no pop");
    issue(1, 8'h33, 90, 62, 62, 90, 8'h33, "R5 if-without-else split");
    issue(1, 8'hFF, 62, 91, 0, 62, 8'hFF, "R5 no empty path issued");
    issue(0, 8'h00, 0, 0, 0, 63, 8'hFF, "R5 stack drained");

    held = pc_o;
    repeat (3) @(negedge clk_i);
    check("R2 hold pc without step", int'(pc_o), int'(held));
    check("R2 hold mask without step", int'(lane_en_o), 'hFF);
    check("R7 overflow sticky", int'(overflow_o), 1);

    rst_i = 1'b1;
    @(negedge clk_i);
    rst_i = 1'b0;
    @(negedge clk_i);
    check("R1 reset clears overflow", int'(overflow_o), 0);
    check("R1 reset pc again", int'(pc_o), 0);
    issue(0, 8'h00, 0, 0, 0, 1, 8'hFF, "R1 empty stack after reset");
    @(negedge clk_i);
    check("all expected results consumed", q_pc.size(), 0);
    finish_run();
  end
endmodule